// File: doc/BRIEF.md
# Scatter-Gather List Walker

This block is the engine of a single DMA channel. Software builds a chain of 8-byte descriptor records in memory, one after another, and hands the engine the address of the first. The engine reads each record over a simple request/grant memory port, decodes it, and moves the number of bytes the record names between a buffer in memory and a word-wide device stream. It keeps walking forward until it retires a record marked as the end of the chain, then raises a sticky done flag.

A parameter fixes the channel's direction when the block is built. A receive channel takes words from a device source and writes them to memory. It is started by setting its run control. It also carries a row-size setting that marks the end of each video line. A transmit channel reads memory and hands the words to a device sink. It is started by the write of the list address itself. Clearing the run control stops either direction cleanly at a beat boundary. A record whose valid flag is clear stops the channel and raises an error flag.

Top module: `sgl_walker`

## Requirements
- R1: After reset, busy, done, err and row_end are low, and the block asserts no memory request, no source ready and no sink valid.
- R2: Every record is two little-endian words, read in order: first the word at the record address, then the word at the record address plus 4. In word 0, bit 0 is valid, bit 1 is end of chain, bit 5 is transfer, bits 15:8 are reserved, and bits 31:16 hold the byte length. Word 1 is the buffer address. The following record starts at the record address plus 8.
- R3: Receive: each word accepted from the source is written to memory, the first at the buffer address and each later one 4 bytes higher, for length/4 words in arrival order. A write that has not been granted keeps its request, address and data unchanged.
- R4: Transmit: the buffer words are read in address order and each is offered on the sink, for length/4 words. The sink valid and its data stay unchanged until ready is seen.
- R5: done rises only on the same clock edge at which busy falls, after the final beat of the record with the end flag. It stays high while idle and clears when the next run starts.
- R6: A record with bit 0 clear moves no data. It sets err, returns the block to idle and leaves done low.
- R7: A valid record with bit 5 clear moves no data, whatever its length field holds. The walk then continues to the next record, and the end flag is still honoured.
- R8: Config port encoding: select 0 is the list address, select 1 is the upper address (ignored), select 2 is run control (bit 0), and select 3 is row bytes (bits 15:0). A receive channel starts only on a select-2 write with bit 0 set while idle. A transmit channel starts only on a select-0 write while idle. A select-1 write never starts either direction.
- R9: A select-2 write with bit 0 clear while busy lets the beat in flight finish, then returns to idle with done low. After that, no source word is accepted.
- R10: Receive only: row_end pulses for one cycle, in the cycle after the memory write that brings the bytes counted in the current row up to the row-bytes value. The count carries across records, restarts at each start, and a row-bytes value of 0 disables the pulse.
- R11: A valid transfer record with length 0 moves no data, and the walk goes on.
- R12: At most one memory read is outstanding: no request is raised between a granted read and its returned data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Config write strobe |
| cfg_sel | input | 2 | Config register select |
| cfg_wdata | input | 32 | Config write data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Memory request accepted |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Read data |
| src_valid | input | 1 | Device source word valid (receive) |
| src_ready | output | 1 | Engine accepts source word |
| src_data | input | 32 | Device source word |
| snk_valid | output | 1 | Word offered to device sink (transmit) |
| snk_ready | input | 1 | Device sink accepts word |
| snk_data | output | 32 | Word to device sink |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Chain completed (sticky until next start) |
| err | output | 1 | Invalid record seen (sticky until next start) |
| row_end | output | 1 | One-cycle end-of-row pulse (receive) |

## Verification
Some internal faults show up at the ports within one record. A bad record pointer or a misdecoded header shows up at once as memory writes to the wrong address, or as missing or extra sink words. A length counter that is off by one beat shows up as one beat too many or too few before the next header fetch. Faults in completion or stop handling are only seen when the run ends: done raised before the last write, done raised after a stop, or a source still accepted after the walk has stopped. A bad row counter shifts the row_end pulses by whole beats. Comparing all memory writes, sink words and flags against an ordered expectation list catches each of these cases within a few cycles.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  localparam int unsigned ADDR_W     = 32;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned LEN_W      = 16;
  localparam int unsigned ROW_W      = 16;
  localparam int unsigned SEL_W      = 2;
  localparam int unsigned BEAT_BYTES = WORD_W / 8;
  localparam int unsigned REC_BYTES  = 8;

  localparam int unsigned CB_VALID = 0;
  localparam int unsigned CB_END   = 1;
  localparam int unsigned CB_XFER  = 5;

  localparam logic [SEL_W-1:0] SEL_BASE    = 2'd0;
  localparam logic [SEL_W-1:0] SEL_BASE_HI = 2'd1;
  localparam logic [SEL_W-1:0] SEL_RUN     = 2'd2;
  localparam logic [SEL_W-1:0] SEL_ROW     = 2'd3;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LEN_W-1:0]  len_t;

  typedef enum logic [1:0] {W_IDLE, W_HDR, W_PTR, W_XFER} walk_st_t;

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic [7:0]       rsvd;
    logic [7:0]       ctrl;
  } rec_hdr_t;

  function automatic addr_t next_record(input addr_t at);
    return at + addr_t'(REC_BYTES);
  endfunction

  function automatic len_t len_after_beat(input len_t rem);
    return (rem > len_t'(BEAT_BYTES)) ? rem - len_t'(BEAT_BYTES) : '0;
  endfunction

  function automatic logic row_fills(input logic [ROW_W-1:0] cnt, input logic [ROW_W-1:0] row);
    return ({1'b0, cnt} + (ROW_W+1)'(BEAT_BYTES)) >= {1'b0, row};
  endfunction
endpackage

// File: rtl/sgw_regs.sv
module sgw_regs import sgw_pkg::*; #(
  parameter bit RX_MODE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic             busy,
  input  logic             finish,
  output addr_t            base,
  output logic [ROW_W-1:0] row_bytes,
  output logic             run,
  output logic             start
);
  logic start_ev, halt_ev, go_wr, base_wr;

  assign go_wr    = cfg_we && (cfg_sel == SEL_RUN);
  assign base_wr  = cfg_we && (cfg_sel == SEL_BASE);
  assign start_ev = !busy && !run && (RX_MODE ? (go_wr && cfg_wdata[0]) : base_wr);
  assign halt_ev  = go_wr && !cfg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base      <= '0;
      row_bytes <= '0;
      run       <= 1'b0;
      start     <= 1'b0;
    end else begin
      start <= start_ev;
      if (base_wr) base <= addr_t'(cfg_wdata);
      if (cfg_we && (cfg_sel == SEL_ROW)) row_bytes <= cfg_wdata[ROW_W-1:0];
      if (start_ev) run <= 1'b1;
      else if (halt_ev || finish) run <= 1'b0;
    end
  end
endmodule

// File: rtl/sgw_walker.sv
module sgw_walker import sgw_pkg::*; #(
  parameter bit RX_MODE = 1'b1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  logic  run,
  input  addr_t base,
  output logic  mem_req,
  output logic  mem_we,
  output addr_t mem_addr,
  output word_t mem_wdata,
  input  logic  mem_gnt,
  input  logic  mem_rvalid,
  input  word_t mem_rdata,
  input  logic  src_valid,
  output logic  src_ready,
  input  word_t src_data,
  output logic  snk_valid,
  input  logic  snk_ready,
  output word_t snk_data,
  output logic  busy,
  output logic  done,
  output logic  err,
  output logic  finish,
  output logic  beat
);
  walk_st_t st;
  addr_t    cur_rec, buf_addr;
  len_t     remain;
  word_t    word_q;
  logic     last_f, waiting, holding, done_q, err_q;
  rec_hdr_t hdr;

  logic at_rest, rsp_in, rd_acc, wr_acc, stop_now, retire, bad_hdr;
  logic unused_walk;

  assign hdr      = rec_hdr_t'(mem_rdata);
  assign at_rest  = !waiting && !holding;
  assign rsp_in   = waiting && mem_rvalid;
  assign rd_acc   = mem_req && mem_gnt && !mem_we;
  assign wr_acc   = mem_req && mem_gnt && mem_we;
  assign stop_now = (st != W_IDLE) && at_rest && !run;
  assign retire   = (st == W_XFER) && at_rest && run && (remain == '0);
  assign bad_hdr  = (st == W_HDR) && rsp_in && !hdr.ctrl[CB_VALID];
  assign finish   = (retire && last_f) || bad_hdr;

  always_comb begin
    mem_req  = 1'b0;
    mem_we   = 1'b0;
    mem_addr = cur_rec;
    unique case (st)
      W_HDR: mem_req = !waiting && run;
      W_PTR: begin
        mem_req  = !waiting && run;
        mem_addr = cur_rec + addr_t'(BEAT_BYTES);
      end
      W_XFER: begin
        mem_addr = buf_addr;
        if (RX_MODE) begin
          mem_req = holding;
          mem_we  = 1'b1;
        end else begin
          mem_req = at_rest && run && (remain != '0);
        end
      end
      default: ;
    endcase
  end

  assign mem_wdata = word_q;
  assign snk_data  = word_q;
  assign src_ready = RX_MODE && (st == W_XFER) && at_rest && run && (remain != '0);
  assign snk_valid = !RX_MODE && holding;
  assign beat      = RX_MODE ? wr_acc : (snk_valid && snk_ready);
  assign busy      = (st != W_IDLE);
  assign done      = done_q;
  assign err       = err_q;
  assign unused_walk = ^{hdr.rsvd, src_valid, src_data, snk_ready};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= W_IDLE;
      cur_rec  <= '0;
      buf_addr <= '0;
      remain   <= '0;
      word_q   <= '0;
      last_f   <= 1'b0;
      waiting  <= 1'b0;
      holding  <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (rd_acc) waiting <= 1'b1;
      else if (rsp_in) waiting <= 1'b0;
      unique case (st)
        W_IDLE: if (start) begin
          st      <= W_HDR;
          cur_rec <= base;
          done_q  <= 1'b0;
          err_q   <= 1'b0;
        end
        W_HDR: begin
          if (stop_now) st <= W_IDLE;
          else if (rsp_in) begin
            if (!hdr.ctrl[CB_VALID]) begin
              err_q <= 1'b1;
              st    <= W_IDLE;
            end else begin
              last_f <= hdr.ctrl[CB_END];
              remain <= hdr.ctrl[CB_XFER] ? hdr.len : '0;
              st     <= W_PTR;
            end
          end
        end
        W_PTR: begin
          if (stop_now) st <= W_IDLE;
          else if (rsp_in) begin
            buf_addr <= mem_rdata;
            st       <= W_XFER;
          end
        end
        W_XFER: begin
          if (stop_now) st <= W_IDLE;
          else if (retire) begin
            if (last_f) begin
              done_q <= 1'b1;
              st     <= W_IDLE;
            end else begin
              cur_rec <= next_record(cur_rec);
              st      <= W_HDR;
            end
          end else begin
            if (RX_MODE && src_ready && src_valid) begin
              word_q  <= src_data;
              holding <= 1'b1;
            end
            if (!RX_MODE && rsp_in) begin
              word_q  <= mem_rdata;
              holding <= 1'b1;
            end
            if (beat) begin
              holding  <= 1'b0;
              remain   <= len_after_beat(remain);
              buf_addr <= buf_addr + addr_t'(BEAT_BYTES);
            end
          end
        end
        default: st <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sgw_rowpace.sv
module sgw_rowpace import sgw_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             beat,
  input  logic [ROW_W-1:0] row_bytes,
  output logic             row_end
);
  logic [ROW_W-1:0] row_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_cnt <= '0;
      row_end <= 1'b0;
    end else begin
      row_end <= 1'b0;
      if (start) row_cnt <= '0;
      else if (beat) begin
        if ((row_bytes != '0) && row_fills(row_cnt, row_bytes)) begin
          row_cnt <= '0;
          row_end <= 1'b1;
        end else begin
          row_cnt <= row_cnt + ROW_W'(BEAT_BYTES);
        end
      end
    end
  end
endmodule

// File: rtl/sgl_walker.sv
module sgl_walker import sgw_pkg::*; #(
  parameter bit RX_MODE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              src_valid,
  output logic              src_ready,
  input  logic [WORD_W-1:0] src_data,
  output logic              snk_valid,
  input  logic              snk_ready,
  output logic [WORD_W-1:0] snk_data,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              row_end
);
  addr_t            base;
  logic [ROW_W-1:0] row_bytes;
  logic             run, start, finish, beat;

  sgw_regs #(.RX_MODE(RX_MODE)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .busy(busy), .finish(finish),
    .base(base), .row_bytes(row_bytes), .run(run), .start(start)
  );

  sgw_walker #(.RX_MODE(RX_MODE)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(start), .run(run), .base(base),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .src_valid(src_valid), .src_ready(src_ready),
    .src_data(src_data), .snk_valid(snk_valid), .snk_ready(snk_ready),
    .snk_data(snk_data), .busy(busy), .done(done), .err(err),
    .finish(finish), .beat(beat)
  );

  generate
    if (RX_MODE) begin : g_row
      sgw_rowpace u_row (
        .clk(clk), .rst_n(rst_n), .start(start), .beat(beat),
        .row_bytes(row_bytes), .row_end(row_end)
      );
    end else begin : g_norow
      logic unused_row;
      assign unused_row = ^row_bytes;
      assign row_end    = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/sgw_checker.sv
module sgw_checker import sgw_pkg::*; (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [WORD_W-1:0] mem_wdata,
  input logic              mem_gnt,
  input logic              mem_rvalid,
  input logic              src_ready,
  input logic              snk_valid,
  input logic              snk_ready,
  input logic [WORD_W-1:0] snk_data,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              row_end
);
  logic rd_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_pend <= 1'b0;
    else if (mem_req && mem_gnt && !mem_we) rd_pend <= 1'b1;
    else if (mem_rvalid) rd_pend <= 1'b0;
  end

  AST_READ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pend |-> !mem_req); // R12
  AST_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && !mem_gnt) |=> (mem_req && mem_we && $stable(mem_addr) && $stable(mem_wdata))); // R3
  AST_SINK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (snk_valid && !snk_ready) |=> (snk_valid && $stable(snk_data))); // R4
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R5
  AST_DONE_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(busy) && !busy)); // R5
  AST_ERR_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !done); // R6
  AST_ROW_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    row_end |-> $past(mem_req && mem_gnt && mem_we)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !src_ready && !snk_valid)); // R9
endmodule

bind sgl_walker sgw_checker u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
  .mem_rvalid(mem_rvalid), .src_ready(src_ready), .snk_valid(snk_valid),
  .snk_ready(snk_ready), .snk_data(snk_data), .busy(busy), .done(done),
  .err(err), .row_end(row_end)
);

// File: tb/tb_sgl_walker.sv
module tb_mem (
  input  logic        clk,
  input  logic        req,
  input  logic        we,
  input  logic [31:0] addr,
  input  logic [31:0] wdata,
  input  logic        stall,
  output logic        gnt,
  output logic        rvalid,
  output logic [31:0] rdata
);
  logic [31:0] words [256];
  assign gnt = req && !stall;
  initial begin
    rvalid = 1'b0;
    rdata  = '0;
    for (int i = 0; i < 256; i++) words[i] = '0;
  end
  always @(posedge clk) begin
    rvalid <= gnt && !we;
    if (gnt && !we) rdata <= words[addr[9:2]];
    if (gnt && we) words[addr[9:2]] <= wdata;
  end
endmodule

module tb_sgl_walker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  int row_seen = 0;
  int ready_seen = 0;

  logic        we_rx = 0, we_tx = 0;
  logic [1:0]  sel = '0;
  logic [31:0] wdata = '0;
  logic        src_valid = 0;
  logic [31:0] src_data = '0;
  logic        stall_en = 0;
  logic [3:0]  stall_pat = 4'b0110;
  logic [3:0]  rdy_pat = 4'b1011;
  logic        stall, snk_ready;

  always @(posedge clk) begin
    stall_pat <= {stall_pat[0], stall_pat[3:1]};
    rdy_pat   <= {rdy_pat[0], rdy_pat[3:1]};
  end
  assign stall     = stall_en && stall_pat[0];
  assign snk_ready = rdy_pat[0];

  logic        rx_req, rx_we, rx_gnt, rx_rv, rx_srdy, rx_svld, rx_busy, rx_done, rx_err, rx_row;
  logic [31:0] rx_addr, rx_wd, rx_rd, rx_sdat;
  logic        tx_req, tx_we, tx_gnt, tx_rv, tx_srdy, tx_svld, tx_busy, tx_done, tx_err, tx_row;
  logic [31:0] tx_addr, tx_wd, tx_rd, tx_sdat;

  sgl_walker #(.RX_MODE(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(we_rx), .cfg_sel(sel), .cfg_wdata(wdata),
    .mem_req(rx_req), .mem_we(rx_we), .mem_addr(rx_addr), .mem_wdata(rx_wd),
    .mem_gnt(rx_gnt), .mem_rvalid(rx_rv), .mem_rdata(rx_rd),
    .src_valid(src_valid), .src_ready(rx_srdy), .src_data(src_data),
    .snk_valid(rx_svld), .snk_ready(1'b1), .snk_data(rx_sdat),
    .busy(rx_busy), .done(rx_done), .err(rx_err), .row_end(rx_row)
  );
  tb_mem m_rx (.clk(clk), .req(rx_req), .we(rx_we), .addr(rx_addr), .wdata(rx_wd),
    .stall(stall), .gnt(rx_gnt), .rvalid(rx_rv), .rdata(rx_rd));

  sgl_walker #(.RX_MODE(1'b0)) dut_tx (
    .clk(clk), .rst_n(rst_n), .cfg_we(we_tx), .cfg_sel(sel), .cfg_wdata(wdata),
    .mem_req(tx_req), .mem_we(tx_we), .mem_addr(tx_addr), .mem_wdata(tx_wd),
    .mem_gnt(tx_gnt), .mem_rvalid(tx_rv), .mem_rdata(tx_rd),
    .src_valid(1'b0), .src_ready(tx_srdy), .src_data(32'h0),
    .snk_valid(tx_svld), .snk_ready(snk_ready), .snk_data(tx_sdat),
    .busy(tx_busy), .done(tx_done), .err(tx_err), .row_end(tx_row)
  );
  tb_mem m_tx (.clk(clk), .req(tx_req), .we(tx_we), .addr(tx_addr), .wdata(tx_wd),
    .stall(stall), .gnt(tx_gnt), .rvalid(tx_rv), .rdata(tx_rd));

  logic [31:0] exp_wa[$];
  logic [31:0] exp_wd[$];
  logic [31:0] exp_tx[$];

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // scoreboard monitor: pops expected items as the designs produce them
  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_req && rx_gnt && rx_we) begin
        if (exp_wa.size() == 0) chk(1'b0, "R3", "unexpected memory write", rx_addr, 32'hFFFF_FFFF);
        else begin
          logic [31:0] ea, ed;
          ea = exp_wa.pop_front();
          ed = exp_wd.pop_front();
          chk(rx_addr == ea, "R3", "write address", rx_addr, ea);
          chk(rx_wd == ed, "R3", "write data", rx_wd, ed);
        end
      end
      if (tx_svld && snk_ready) begin
        if (exp_tx.size() == 0) chk(1'b0, "R4", "unexpected sink word", tx_sdat, 32'hFFFF_FFFF);
        else begin
          logic [31:0] e;
          e = exp_tx.pop_front();
          chk(tx_sdat == e, "R4", "sink word", tx_sdat, e);
        end
      end
      if (rx_row) row_seen++;
      if (rx_srdy && src_valid) ready_seen++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "WD", "watchdog expired", 32'h0, 32'h1);
    finish_run();
  end

  task automatic poke(input bit tx, input int a, input logic [31:0] d);
    if (tx) m_tx.words[a >> 2] = d;
    else    m_rx.words[a >> 2] = d;
  endtask

  task automatic put_rec(input bit tx, input int at, input logic [7:0] ctrl,
                         input logic [15:0] len, input logic [31:0] bufa);
    poke(tx, at, {len, 8'h00, ctrl});
    poke(tx, at + 4, bufa);
  endtask

  task automatic cfg_write(input bit tx, input logic [1:0] s, input logic [31:0] d);
    @(posedge clk); #2;
    sel = s; wdata = d;
    if (tx) we_tx = 1'b1; else we_rx = 1'b1;
    @(posedge clk); #2;
    we_tx = 1'b0; we_rx = 1'b0;
  endtask

  task automatic rx_send(input logic [31:0] a, input logic [31:0] d);
    exp_wa.push_back(a);
    exp_wd.push_back(d);
    src_valid = 1'b1;
    src_data  = d;
    forever begin
      @(negedge clk);
      if (rx_srdy) break;
    end
    @(posedge clk); #2;
    src_valid = 1'b0;
  endtask

  task automatic wait_idle(input bit tx, input string rq);
    int n = 0;
    repeat (3) @(posedge clk);
    while ((tx ? tx_busy : rx_busy) && n < 2000) begin
      @(posedge clk);
      n++;
    end
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(n < 2000, rq, "walk ended", n, 2000);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!rx_busy && !tx_busy, "R1", "busy low", {rx_busy, tx_busy}, 0);
    chk(!rx_done && !rx_err && !tx_done && !tx_err, "R1", "flags low",
        {rx_done, rx_err, tx_done, tx_err}, 0);
    chk(!rx_req && !tx_req && !rx_srdy && !tx_svld && !rx_row, "R1", "handshakes idle",
        {rx_req, tx_req, rx_srdy, tx_svld, rx_row}, 0);

    // Test 1: receive chain of two records, row pacing 8 bytes (R2 R3 R5 R8 R10)
    put_rec(0, 'h040, 8'h21, 16'd12, 32'h200);
    put_rec(0, 'h048, 8'h23, 16'd8,  32'h280);
    cfg_write(0, 2'd3, 32'd8);
    cfg_write(0, 2'd0, 32'h040);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!rx_busy, "R8", "list address write does not start receive", rx_busy, 0);
    row_seen = 0;
    cfg_write(0, 2'd2, 32'd1);
    rx_send(32'h200, 32'hA000_0001);
    @(negedge clk);
    chk(rx_busy, "R8", "receive started by run write", rx_busy, 1);
    rx_send(32'h204, 32'hA000_0002);
    rx_send(32'h208, 32'hA000_0003);
    rx_send(32'h280, 32'hB000_0001);
    @(negedge clk);
    chk(!rx_done, "R5", "done low before final beat", rx_done, 0);
    rx_send(32'h284, 32'hB000_0002);
    wait_idle(0, "R5");
    chk(rx_done && !rx_err, "R5", "done after end record", {rx_done, rx_err}, 2'b10);
    chk(exp_wa.size() == 0, "R2", "all expected writes seen", exp_wa.size(), 0);
    chk(row_seen == 2, "R10", "row pulses for 8-byte rows", row_seen, 2);

    // Test 2: skip record, zero length, stalls, rows disabled (R7 R11 R5 R10)
    stall_en = 1'b1;
    put_rec(0, 'h060, 8'h21, 16'd8, 32'h300);
    put_rec(0, 'h068, 8'h01, 16'd8, 32'h320);
    put_rec(0, 'h070, 8'h21, 16'd0, 32'h330);
    put_rec(0, 'h078, 8'h23, 16'd4, 32'h340);
    cfg_write(0, 2'd3, 32'd0);
    cfg_write(0, 2'd0, 32'h060);
    row_seen = 0;
    cfg_write(0, 2'd2, 32'd1);
    @(posedge clk);
    @(negedge clk);
    chk(!rx_done, "R5", "done cleared at new start", rx_done, 0);
    rx_send(32'h300, 32'hC000_0001);
    rx_send(32'h304, 32'hC000_0002);
    rx_send(32'h340, 32'hC000_0003);
    wait_idle(0, "R7");
    chk(rx_done, "R7", "chain completes past skip record", rx_done, 1);
    chk(exp_wa.size() == 0, "R11", "no writes for empty records", exp_wa.size(), 0);
    chk(row_seen == 0, "R10", "row pulses disabled at zero", row_seen, 0);
    stall_en = 1'b0;

    // Test 3: invalid second record (R6)
    put_rec(0, 'h0A0, 8'h21, 16'd4, 32'h380);
    put_rec(0, 'h0A8, 8'h20, 16'd4, 32'h390);
    cfg_write(0, 2'd0, 32'h0A0);
    cfg_write(0, 2'd2, 32'd1);
    rx_send(32'h380, 32'hD000_0001);
    wait_idle(0, "R6");
    chk(rx_err && !rx_done, "R6", "error without done", {rx_err, rx_done}, 2'b10);
    chk(exp_wa.size() == 0, "R6", "no data for invalid record", exp_wa.size(), 0);

    // Test 4: stop mid-record (R9)
    put_rec(0, 'h0C0, 8'h23, 16'd64, 32'h3C0);
    cfg_write(0, 2'd0, 32'h0C0);
    cfg_write(0, 2'd2, 32'd1);
    rx_send(32'h3C0, 32'hE000_0001);
    rx_send(32'h3C4, 32'hE000_0002);
    rx_send(32'h3C8, 32'hE000_0003);
    repeat (3) @(posedge clk);
    cfg_write(0, 2'd2, 32'd0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(!rx_busy && !rx_done, "R9", "idle without done after stop", {rx_busy, rx_done}, 0);
    ready_seen = 0;
    @(posedge clk); #2;
    src_valid = 1'b1;
    src_data  = 32'hDEAD_BEEF;
    repeat (6) @(posedge clk);
    #2 src_valid = 1'b0;
    @(negedge clk);
    chk(ready_seen == 0, "R9", "no source accepted after stop", ready_seen, 0);
    chk(exp_wa.size() == 0, "R9", "writes before stop completed", exp_wa.size(), 0);

    // Test 5: transmit (R8 R4 R2 R5)
    cfg_write(1, 2'd1, 32'h080);
    cfg_write(1, 2'd2, 32'd1);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!tx_busy, "R8", "upper address and run writes do not start transmit", tx_busy, 0);
    stall_en = 1'b1;
    put_rec(1, 'h080, 8'h21, 16'd8, 32'h300);
    put_rec(1, 'h088, 8'h23, 16'd4, 32'h340);
    poke(1, 'h300, 32'h5500_0001);
    poke(1, 'h304, 32'h5500_0002);
    poke(1, 'h340, 32'h5500_0003);
    exp_tx.push_back(32'h5500_0001);
    exp_tx.push_back(32'h5500_0002);
    exp_tx.push_back(32'h5500_0003);
    cfg_write(1, 2'd0, 32'h080);
    wait_idle(1, "R4");
    chk(tx_done && !tx_err, "R5", "transmit chain done", {tx_done, tx_err}, 2'b10);
    chk(exp_tx.size() == 0, "R4", "all sink words seen", exp_tx.size(), 0);
    stall_en = 1'b0;

    finish_run();
  end
endmodule